// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Input

This block sits beside a processor core and decides which interrupt, if any, the core takes at the next instruction boundary. It watches four request lines. One of them is non-maskable. The other three are maskable restart requests: a low, a middle and a high line. The controller holds a global interrupt-enable flag and one mask bit for each maskable line. Commands from the core set and clear these.

When the core raises its boundary strobe, the controller picks the highest-priority eligible request. On the next cycle it presents a one-cycle grant together with the 16-bit restart address. That grant is also the acknowledge: it clears the enable flag and the latched state of the source it served. The core reads a status word of pending lines, mask bits and the enable flag.

The high line is edge-latched, so a short pulse is not lost. The low and middle lines are level requests. The non-maskable line needs a rising edge and must still be high at the boundary.

Top module: `restart_intc`

## Requirements
- R1: A grant is a one-cycle `grant_valid` pulse in the cycle after `boundary` is high. It carries `grant_vec` = 0x0024 for the non-maskable source, 0x002C for the low line, 0x0034 for the middle line and 0x003C for the high line.
- R2: A pending non-maskable request is granted whatever the enable flag and the mask bits hold.
- R3: `en_cmd` sets the enable flag and `dis_cmd` clears it from the next cycle. When both are high, `dis_cmd` wins. While the flag is 0, no maskable line is granted.
- R4: Every grant, including a non-maskable one, clears the enable flag in the same edge that raises `grant_valid`. Maskable lines then stay blocked until `en_cmd` is given again.
- R5: `mask_wr` loads `mask_wdata` into the mask bits from the next cycle. Bit 0 is the low line, bit 1 the middle line and bit 2 the high line. A 1 blocks the line. `stat_mask` returns the mask bits in the same positions.
- R6: Priority from highest to lowest is non-maskable, high, middle, low. At most one grant is made per boundary.
- R7: A rising edge on `irq_hi` sets a pending bit whether or not the line is masked or the flag is set. A held high level does not set it again. The bit clears only when the high line is granted. `stat_pend` reports bit 0 = `irq_lo` level, bit 1 = `irq_mid` level, bit 2 = the high pending bit.
- R8: A non-maskable request is taken only after a rising edge on `nmi_line`, and only if the line is still high in the boundary cycle. If the line falls first, the request is discarded.
- R9: After reset the enable flag is 0, all three mask bits are 1, the high pending bit is 0 and `grant_valid` is 0.
- R10: `grant_valid` is never high in a cycle that does not follow a `boundary` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_line | input | 1 | Non-maskable request line |
| irq_lo | input | 1 | Low-priority maskable level request |
| irq_mid | input | 1 | Middle-priority maskable level request |
| irq_hi | input | 1 | High-priority maskable edge request |
| en_cmd | input | 1 | Set the interrupt-enable flag |
| dis_cmd | input | 1 | Clear the interrupt-enable flag |
| mask_wr | input | 1 | Load the mask bits |
| mask_wdata | input | 3 | New mask bits (1 = blocked) |
| boundary | input | 1 | Instruction-boundary sampling strobe |
| grant_valid | output | 1 | One-cycle grant and acknowledge |
| grant_vec | output | 16 | Restart address of the granted source |
| stat_pend | output | 3 | Pending status of the three maskable lines |
| stat_mask | output | 3 | Current mask bits |
| stat_ien | output | 1 | Current interrupt-enable flag |

## Verification
The hardest situation to reach from the ports is a high-line request that was latched while blocked. It must survive several grants of other sources and then be served only once. The stimulus pulses `irq_hi` while the line is masked or the flag is clear. It then clears the status check, grants the non-maskable and middle sources ahead of it, and re-enables after each grant so the latched bit finally wins. Last, it holds `irq_hi` high across a grant to show that no second request appears. A non-maskable pulse that falls one cycle before the boundary is also driven, to show that it is dropped.

// File: rtl/rintc_pkg.sv
package rintc_pkg;

    localparam int VEC_W     = 16;
    localparam int N_MSK     = 3;
    localparam int VEC_SHIFT = 3;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0024;

    // bit positions inside mask and status words
    localparam int MB_LO  = 0;
    localparam int MB_MID = 1;
    localparam int MB_HI  = 2;

    // source index also selects the vector slot: base + index * 8
    typedef enum logic [1:0] {
        SRC_NMI = 2'd0,
        SRC_LO  = 2'd1,
        SRC_MID = 2'd2,
        SRC_HI  = 2'd3
    } src_e;

    typedef struct packed {
        logic valid;
        src_e src;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        return VEC_BASE + (VEC_W'(s) << VEC_SHIFT);
    endfunction

endpackage

// File: rtl/rintc_edge_latch.sv
module rintc_edge_latch #(
    parameter bit HOLD_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic line,
    input  logic clr,
    output logic pend
);
    logic prev;
    logic rise;

    assign rise = line & ~prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= line;
    end

    generate
        if (HOLD_LEVEL) begin : g_hold
            // request is dropped as soon as the line falls
            always_ff @(posedge clk) begin
                if (rst) pend <= 1'b0;
                else     pend <= line & (rise | (pend & ~clr));
            end
        end else begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst) pend <= 1'b0;
                else     pend <= rise | (pend & ~clr);
            end
        end
    endgenerate

endmodule

// File: rtl/rintc_pick.sv
module rintc_pick
    import rintc_pkg::*;
(
    input  logic  nmi_ok,
    input  logic  hi_ok,
    input  logic  mid_ok,
    input  logic  lo_ok,
    output pick_t sel
);
    always_comb begin
        sel = '{valid: 1'b0, src: SRC_NMI};
        if (nmi_ok)      sel = '{valid: 1'b1, src: SRC_NMI};
        else if (hi_ok)  sel = '{valid: 1'b1, src: SRC_HI};
        else if (mid_ok) sel = '{valid: 1'b1, src: SRC_MID};
        else if (lo_ok)  sel = '{valid: 1'b1, src: SRC_LO};
    end
endmodule

// File: rtl/restart_intc.sv
module restart_intc
    import rintc_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int NM = N_MSK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nmi_line,
    input  logic          irq_lo,
    input  logic          irq_mid,
    input  logic          irq_hi,
    input  logic          en_cmd,
    input  logic          dis_cmd,
    input  logic          mask_wr,
    input  logic [NM-1:0] mask_wdata,
    input  logic          boundary,
    output logic          grant_valid,
    output logic [VW-1:0] grant_vec,
    output logic [NM-1:0] stat_pend,
    output logic [NM-1:0] stat_mask,
    output logic          stat_ien
);
    logic          ien;
    logic [NM-1:0] mask;
    logic          nmi_pend, hi_pend;
    logic          nmi_clr, hi_clr;
    logic          take;
    pick_t         sel;

    rintc_edge_latch #(.HOLD_LEVEL(1'b1)) u_nmi_latch (
        .clk(clk), .rst(rst), .line(nmi_line), .clr(nmi_clr), .pend(nmi_pend)
    );

    rintc_edge_latch #(.HOLD_LEVEL(1'b0)) u_hi_latch (
        .clk(clk), .rst(rst), .line(irq_hi), .clr(hi_clr), .pend(hi_pend)
    );

    rintc_pick u_pick (
        .nmi_ok (nmi_pend & nmi_line),
        .hi_ok  (ien & ~mask[MB_HI]  & hi_pend),
        .mid_ok (ien & ~mask[MB_MID] & irq_mid),
        .lo_ok  (ien & ~mask[MB_LO]  & irq_lo),
        .sel    (sel)
    );

    assign take    = boundary & sel.valid;
    assign nmi_clr = take & (sel.src == SRC_NMI);
    assign hi_clr  = take & (sel.src == SRC_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            grant_vec   <= '0;
            ien         <= 1'b0;
            mask        <= '1;
        end else begin
            grant_valid <= take;
            if (take) grant_vec <= VW'(vec_of(sel.src));
            if (take)         ien <= 1'b0;
            else if (dis_cmd) ien <= 1'b0;
            else if (en_cmd)  ien <= 1'b1;
            if (mask_wr) mask <= mask_wdata;
        end
    end

    always_comb begin
        stat_pend          = '0;
        stat_pend[MB_LO]   = irq_lo;
        stat_pend[MB_MID]  = irq_mid;
        stat_pend[MB_HI]   = hi_pend;
    end
    assign stat_mask = mask;
    assign stat_ien  = ien;

endmodule

// File: rtl/restart_intc_checker.sv
module restart_intc_checker #(
    parameter int VW = 16,
    parameter int NM = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          nmi_line,
    input logic          irq_hi,
    input logic          dis_cmd,
    input logic          mask_wr,
    input logic [NM-1:0] mask_wdata,
    input logic          boundary,
    input logic          grant_valid,
    input logic [VW-1:0] grant_vec,
    input logic [NM-1:0] stat_pend,
    input logic [NM-1:0] stat_mask,
    input logic          stat_ien,
    input logic          nmi_pend
);
    a_r10_only_after_boundary: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> $past(boundary));

    a_r4_grant_clears_enable: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !stat_ien);

    a_r2_nmi_bypass: assert property (@(posedge clk) disable iff (rst)
        (boundary && nmi_pend && nmi_line) |=> (grant_valid && grant_vec == VW'(16'h0024)));

    a_r6_hi_over_lower: assert property (@(posedge clk) disable iff (rst)
        (boundary && stat_ien && !stat_mask[2] && stat_pend[2] && !(nmi_pend && nmi_line))
        |=> (grant_valid && grant_vec == VW'(16'h003C)));

    a_r7_edge_latches: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_hi) |=> stat_pend[2]);

    a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
        $past(dis_cmd) && !$past(rst) |-> !stat_ien);

    a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
        $past(mask_wr) && !$past(rst) |-> stat_mask == $past(mask_wdata));

    a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_mask == '1 && !stat_ien && !grant_valid && !stat_pend[2]));

endmodule

bind restart_intc restart_intc_checker #(.VW(VW), .NM(NM)) u_chk (
    .clk(clk), .rst(rst), .nmi_line(nmi_line), .irq_hi(irq_hi),
    .dis_cmd(dis_cmd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .boundary(boundary), .grant_valid(grant_valid), .grant_vec(grant_vec),
    .stat_pend(stat_pend), .stat_mask(stat_mask), .stat_ien(stat_ien),
    .nmi_pend(nmi_pend)
);

// File: tb/restart_intc_bench.sv
module restart_intc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_line = 0, irq_lo = 0, irq_mid = 0, irq_hi = 0;
    logic        en_cmd = 0, dis_cmd = 0, mask_wr = 0, boundary = 0;
    logic [2:0]  mask_wdata = 3'b000;
    logic        grant_valid;
    logic [15:0] grant_vec;
    logic [2:0]  stat_pend, stat_mask;
    logic        stat_ien;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        bit          v;
        logic [15:0] vec;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    restart_intc u_restart_intc (
        .clk(clk), .rst(rst), .nmi_line(nmi_line), .irq_lo(irq_lo),
        .irq_mid(irq_mid), .irq_hi(irq_hi), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .boundary(boundary),
        .grant_valid(grant_valid), .grant_vec(grant_vec), .stat_pend(stat_pend),
        .stat_mask(stat_mask), .stat_ien(stat_ien)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_en();
        @(negedge clk) en_cmd = 1;
        @(negedge clk) en_cmd = 0;
    endtask

    task automatic do_dis();
        @(negedge clk) dis_cmd = 1;
        @(negedge clk) dis_cmd = 0;
    endtask

    task automatic do_mask(input logic [2:0] m);
        @(negedge clk) begin mask_wr = 1; mask_wdata = m; end
        @(negedge clk) mask_wr = 0;
    endtask

    // driver: one boundary cycle, expected outcome queued for the monitor
    task automatic bnd(input bit v, input logic [15:0] vec, input string tag);
        exp_t e;
        e.v = v; e.vec = vec; e.tag = tag;
        @(negedge clk) begin boundary = 1; q.push_back(e); end
        @(negedge clk) boundary = 0;
    endtask

    // monitor: compares the grant in the cycle after every boundary; R10 otherwise
    initial begin
        bit was_bnd;
        exp_t e;
        forever begin
            @(posedge clk) was_bnd = boundary && !rst;
            @(negedge clk);
            if (was_bnd) begin
                e = q.pop_front();
                chk(grant_valid == e.v, {e.tag, " grant_valid"}, grant_valid, e.v);
                if (e.v) chk(grant_vec == e.vec, {e.tag, " grant_vec"}, grant_vec, e.vec);
            end else if (!rst) begin
                chk(grant_valid == 1'b0, "R10 no grant without boundary", grant_valid, 0);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        // R9 reset state
        chk(stat_mask == 3'b111, "R9 masks set", stat_mask, 3'b111);
        chk(stat_ien == 1'b0, "R9 enable clear", stat_ien, 0);
        chk(stat_pend == 3'b000, "R9 nothing pending", stat_pend, 0);
        chk(grant_valid == 1'b0, "R9 no grant", grant_valid, 0);

        // R2 non-maskable with enable clear and all masks set
        nmi_line = 1; step();
        bnd(1, 16'h0024, "R2 nmi bypass");
        chk(stat_ien == 1'b0, "R4 enable clear after nmi", stat_ien, 0);
        nmi_line = 0; step();

        // R8 pulse that falls before the boundary is dropped
        nmi_line = 1; step();
        nmi_line = 0;
        bnd(0, 16'h0, "R8 dropped nmi");

        // R3 enable
        do_en();
        chk(stat_ien == 1'b1, "R3 enable set", stat_ien, 1);

        // R5 masked low line
        irq_lo = 1;
        bnd(0, 16'h0, "R5 masked low");
        chk(stat_ien == 1'b1, "R5 enable untouched", stat_ien, 1);
        do_mask(3'b000);
        chk(stat_mask == 3'b000, "R5 mask readback", stat_mask, 0);
        bnd(1, 16'h002C, "R1 low vector");
        chk(stat_ien == 1'b0, "R4 enable cleared by grant", stat_ien, 0);
        bnd(0, 16'h0, "R4 blocked until re-enable");

        // R6 middle over low
        do_en();
        irq_mid = 1;
        bnd(1, 16'h0034, "R6 middle over low");
        irq_mid = 0; irq_lo = 0;

        // R7 edge latch while disabled
        irq_hi = 1; step();
        irq_hi = 0; step();
        chk(stat_pend == 3'b100, "R7 high latched", stat_pend, 3'b100);
        do_en();
        bnd(1, 16'h003C, "R1 high vector");
        chk(stat_pend == 3'b000, "R7 cleared on grant", stat_pend, 0);

        // R6 full ordering
        irq_hi = 1; step();
        irq_hi = 0;
        nmi_line = 1; irq_lo = 1;
        do_en();
        bnd(1, 16'h0024, "R6 nmi first");
        nmi_line = 0;
        chk(stat_pend[2] == 1'b1, "R6 high kept pending", stat_pend[2], 1);
        do_en();
        bnd(1, 16'h003C, "R6 high over low");
        do_en();
        bnd(1, 16'h002C, "R6 low last");
        irq_lo = 0;

        // R3 disable and collision
        do_en(); do_dis();
        chk(stat_ien == 1'b0, "R3 disable clears", stat_ien, 0);
        irq_lo = 1;
        bnd(0, 16'h0, "R3 disabled blocks low");
        @(negedge clk) begin en_cmd = 1; dis_cmd = 1; end
        @(negedge clk) begin en_cmd = 0; dis_cmd = 0; end
        chk(stat_ien == 1'b0, "R3 disable wins", stat_ien, 0);
        irq_lo = 0;

        // R5 high masked while middle is served; latch survives
        do_mask(3'b100);
        irq_hi = 1; step();
        irq_hi = 0; irq_mid = 1;
        do_en();
        bnd(1, 16'h0034, "R5 high masked, middle served");
        chk(stat_pend[2] == 1'b1, "R7 held while masked", stat_pend[2], 1);
        irq_mid = 0;
        do_mask(3'b000);
        do_en();
        bnd(1, 16'h003C, "R5 high after unmask");

        // R7 held level does not re-request
        irq_hi = 1; step();
        do_en();
        bnd(1, 16'h003C, "R7 first edge");
        do_en();
        bnd(0, 16'h0, "R7 no re-pend while held");
        irq_hi = 0;
        step(); step();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule